// File: doc/BRIEF.md
# Paged Channel-List Sequencer

This block holds the scan list for a multiplexed acquisition front end. Each list entry is one byte that pairs an input channel number with a gain code. The list is split into four independent pages. A pointer walks a window bounded by a start register and a final register, and it returns to the start after it reaches the final address. Software reaches the list through three paths. A control word carries a mode code and a page select. A list data port carries the entries. Two strobes write the window bounds.

The mode code decides what a data-port access does. Mode 5 loads entries into the list. Mode 4 reads them back for diagnostics, and each read returns the entry address alongside its contents. Mode 6 arms the sequencer and presets the channel and gain outputs from the first entry of the window. Mode 0 is the running mode: each conversion-done pulse moves the sequencer to the next entry of the window on the selected page.

Top module: `chanlist_seq`

## Requirements
- R1: An entry keeps the channel number in bits 5:0 and the gain code in bits 7:6. The output `chan_out` shows bits 5:0 of the active entry.
- R2: `gain_sel` is one-hot and its value equals the gain: code 0 gives 4'b0001 (gain 1), code 1 gives 4'b0010 (gain 2), code 2 gives 4'b0100 (gain 4), and code 3 gives 4'b1000 (gain 8).
- R3: A `ctl_wr` strobe latches the mode from `ctl_wdata[10:8]` and the page from `ctl_wdata[2:1]`. The page picks which quarter of the list every data-port access and every conversion step uses. The four pages hold separate contents.
- R4: In mode 5, each `list_wr` stores `list_wdata` at the pointer on the selected page and then moves the pointer on.
- R5: When the pointer equals the final address, the next step reloads it with the start address. Any other step adds one. As a result, extra loads overwrite the window from its first entry.
- R6: In mode 4, each `list_rd` moves the pointer on using the R5 rule. One clock later, `list_rdata[15:8]` shows the address that was read, zero-extended, and `list_rdata[7:0]` shows the entry stored there.
- R7: In mode 6, a `list_wr` with any data does three things: it sets `armed`, it loads the pointer with the start address, and two clock edges later it shows the start entry's channel and gain at the outputs. The written data is not stored.
- R8: In mode 0 and in any mode code other than 4, 5 or 6, `list_wr` changes neither the list nor the pointer.
- R9: While `armed` is set and the mode is 0, a one-cycle `conv_done` moves the pointer with the R5 rule. Two clock edges later, the outputs show the new entry.
- R10: While the block is disarmed, or while the mode is not 0, `conv_done` leaves the outputs unchanged.
- R11: `start_wr` latches `bound_wdata` as the start address and also loads the pointer with it. `final_wr` latches the final address.
- R12: A synchronous `rst` clears the mode, page, bounds, pointer and `armed`, and sets the outputs to channel 0 at gain 1. The list contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Strobe that writes the control word |
| ctl_wdata | input | 16 | Control word: mode in bits 10:8, page in bits 2:1 |
| start_wr | input | 1 | Strobe that writes the start address (also loads the pointer) |
| final_wr | input | 1 | Strobe that writes the final address |
| bound_wdata | input | ADDR_W | Address value for `start_wr` and `final_wr` |
| list_wr | input | 1 | Write strobe for the list data port |
| list_wdata | input | 8 | Entry byte for the list data port |
| list_rd | input | 1 | Read strobe for the list data port |
| list_rdata | output | 16 | Readback word: address in the high byte, entry in the low byte |
| conv_done | input | 1 | One-cycle pulse at the end of each conversion |
| armed | output | 1 | Set after a preload; the sequencer follows conversions |
| chan_out | output | CH_W | Active channel number |
| gain_sel | output | 2**GAIN_W | One-hot gain select |

## Verification
The bench builds the block with `ADDR_W` = 4. Each page then holds 16 entries, and the whole list is 64 bytes. This makes it cheap to fill every page completely and read every location back, including one pass past the final address to show the wrap. It also allows narrow windows in the middle of a page, where the wrap lands on a start address that is not zero, during both loading and conversion stepping. Channel and gain widths stay at their defaults, so every gain code appears in the fill pattern.

// File: rtl/chanlist_pkg.sv
package chanlist_pkg;
  localparam int MODE_W   = 3;
  localparam int MODE_LSB = 8;
  localparam int PAGE_LSB = 1;
  localparam int BYTE_W   = 8;

  localparam logic [MODE_W-1:0] MODE_RUN  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_READ = 3'd4;
  localparam logic [MODE_W-1:0] MODE_LOAD = 3'd5;
  localparam logic [MODE_W-1:0] MODE_ARM  = 3'd6;
endpackage

// File: rtl/cl_ctrl_regs.sv
module cl_ctrl_regs
  import chanlist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  input  logic              start_wr,
  input  logic              final_wr,
  input  logic [ADDR_W-1:0] bound_wdata,
  output logic [MODE_W-1:0] mode,
  output logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] final_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_RUN;
      page       <= '0;
      start_addr <= '0;
      final_addr <= '0;
    end else begin
      if (ctl_wr) begin
        mode <= ctl_wdata[MODE_LSB +: MODE_W];
        page <= ctl_wdata[PAGE_LSB +: PAGE_W];
      end
      if (start_wr) start_addr <= bound_wdata;
      if (final_wr) final_addr <= bound_wdata;
    end
  end
endmodule

// File: rtl/cl_pointer.sv
module cl_pointer #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] final_addr,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_next
);
  always_comb begin
    if (ptr == final_addr) ptr_next = start_addr;
    else                   ptr_next = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_next;
  end
endmodule

// File: rtl/cl_list_ram.sv
module cl_list_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chanlist_seq.sv
module chanlist_seq
  import chanlist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 2,
  parameter int CH_W   = 6,
  parameter int GAIN_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_wr,
  input  logic [15:0]            ctl_wdata,
  input  logic                   start_wr,
  input  logic                   final_wr,
  input  logic [ADDR_W-1:0]      bound_wdata,
  input  logic                   list_wr,
  input  logic [7:0]             list_wdata,
  input  logic                   list_rd,
  output logic [15:0]            list_rdata,
  input  logic                   conv_done,
  output logic                   armed,
  output logic [CH_W-1:0]        chan_out,
  output logic [(1<<GAIN_W)-1:0] gain_sel
);
  localparam int ENTRY_W = CH_W + GAIN_W;
  localparam int GAIN_N  = 1 << GAIN_W;
  localparam int RAM_AW  = PAGE_W + ADDR_W;

  logic [MODE_W-1:0]  mode;
  logic [PAGE_W-1:0]  page;
  logic [ADDR_W-1:0]  start_addr, final_addr, ptr, ptr_next;
  logic [ADDR_W-1:0]  load_val, rd_addr_q, ram_ptr;
  logic [RAM_AW-1:0]  raddr;
  logic [ENTRY_W-1:0] dq;
  logic               wr_en, rd_en, arm_en, adv_en, step, ptr_load, upd_q;
  logic [BYTE_W-1:0]  hi_b, lo_b;

  cl_ctrl_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .start_wr(start_wr), .final_wr(final_wr), .bound_wdata(bound_wdata),
    .mode(mode), .page(page), .start_addr(start_addr), .final_addr(final_addr)
  );

  // access decode
  assign wr_en    = list_wr && (mode == MODE_LOAD);
  assign rd_en    = list_rd && (mode == MODE_READ);
  assign arm_en   = list_wr && (mode == MODE_ARM);
  assign adv_en   = conv_done && armed && (mode == MODE_RUN);
  assign step     = wr_en || rd_en || adv_en;
  assign ptr_load = start_wr || arm_en;
  assign load_val = start_wr ? bound_wdata : start_addr;

  cl_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(load_val), .step(step),
    .start_addr(start_addr), .final_addr(final_addr),
    .ptr(ptr), .ptr_next(ptr_next)
  );

  // single read port: preload looks at start, a step looks ahead
  always_comb begin
    if (arm_en)      ram_ptr = start_addr;
    else if (adv_en) ram_ptr = ptr_next;
    else             ram_ptr = ptr;
  end
  assign raddr = {page, ram_ptr};

  cl_list_ram #(.AW(RAM_AW), .DW(ENTRY_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr({page, ptr}), .wdata(list_wdata[ENTRY_W-1:0]),
    .re(rd_en || arm_en || adv_en), .raddr(raddr), .rdata(dq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      upd_q     <= 1'b0;
      rd_addr_q <= '0;
      chan_out  <= '0;
      gain_sel  <= GAIN_N'(1);
    end else begin
      if (arm_en) armed <= 1'b1;
      upd_q <= arm_en || adv_en;
      if (rd_en) rd_addr_q <= ptr;
      if (upd_q) begin
        chan_out <= dq[CH_W-1:0];
        gain_sel <= GAIN_N'(1) << dq[ENTRY_W-1:CH_W];
      end
    end
  end

  always_comb begin
    hi_b = '0;
    lo_b = '0;
    hi_b[ADDR_W-1:0]  = rd_addr_q;
    lo_b[ENTRY_W-1:0] = dq;
  end
  assign list_rdata = {hi_b, lo_b};
endmodule

// File: rtl/cl_seq_chk.sv
module cl_seq_chk
  import chanlist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int GAIN_N = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              list_wr,
  input logic              list_rd,
  input logic              conv_done,
  input logic              start_wr,
  input logic              armed,
  input logic [MODE_W-1:0] mode,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] final_addr,
  input logic [15:0]       list_rdata,
  input logic [GAIN_N-1:0] gain_sel,
  input logic [5:0]        chan_out
);
  p_gain_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(gain_sel) == 1);

  p_arm_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (list_wr && mode == MODE_ARM) |=> armed);

  p_armed_holds_r12: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (list_wr && mode == MODE_LOAD && !start_wr && ptr == final_addr)
      |=> ptr == $past(start_addr));

  p_run_write_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (list_wr && mode == MODE_RUN && !conv_done && !start_wr) |=> $stable(ptr));

  p_rd_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (list_rd && mode == MODE_READ) |=> list_rdata[15:8] == 8'($past(ptr)));

  p_disarmed_still_r10: assert property (@(posedge clk) disable iff (rst)
    !armed |=> ($stable(chan_out) && $stable(gain_sel)));
endmodule

bind chanlist_seq cl_seq_chk #(.ADDR_W(ADDR_W), .GAIN_N(1 << GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .list_wr(list_wr), .list_rd(list_rd),
  .conv_done(conv_done), .start_wr(start_wr), .armed(armed), .mode(mode),
  .ptr(ptr), .start_addr(start_addr), .final_addr(final_addr),
  .list_rdata(list_rdata), .gain_sel(gain_sel), .chan_out(chan_out[5:0])
);

// File: tb/chanlist_seq_tb.sv
module chanlist_seq_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, start_wr = 0, final_wr = 0, list_wr = 0, list_rd = 0, conv_done = 0;
  logic [15:0] ctl_wdata = '0;
  logic [AW-1:0] bound_wdata = '0;
  logic [7:0] list_wdata = '0;
  logic [15:0] list_rdata;
  logic armed;
  logic [5:0] chan_out;
  logic [3:0] gain_sel;

  int n_chk = 0, n_fail = 0;
  logic [7:0] expm [4*DEPTH];

  always #10 clk = ~clk;

  chanlist_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .start_wr(start_wr), .final_wr(final_wr), .bound_wdata(bound_wdata),
    .list_wr(list_wr), .list_wdata(list_wdata), .list_rd(list_rd),
    .list_rdata(list_rdata), .conv_done(conv_done), .armed(armed),
    .chan_out(chan_out), .gain_sel(gain_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic ctl(input logic [2:0] m, input logic [1:0] p);
    @(negedge clk);
    ctl_wdata = {5'b0, m, 5'b0, p, 1'b0};
    ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic setwin(input logic [AW-1:0] s, input logic [AW-1:0] f);
    @(negedge clk);
    bound_wdata = s; start_wr = 1;
    @(negedge clk);
    start_wr = 0; bound_wdata = f; final_wr = 1;
    @(negedge clk);
    final_wr = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    list_wdata = d; list_wr = 1;
    @(negedge clk);
    list_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk);
    list_rd = 1;
    @(negedge clk);
    list_rd = 0;
  endtask

  task automatic conv();
    @(negedge clk);
    conv_done = 1;
    @(negedge clk);
    conv_done = 0;
    @(negedge clk);
  endtask

  task automatic chk_out(input string req, input int idx);
    chk(req, {26'd0, chan_out}, {26'd0, expm[idx][5:0]});
    chk("R2 gain", {28'd0, gain_sel}, 32'd1 << expm[idx][7:6]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 71 + i * 29 + 5) & 255);
  endfunction

  initial begin
    #4ms;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 armed", {31'd0, armed}, 0);
    chk("R12 chan", {26'd0, chan_out}, 0);
    chk("R12 gain", {28'd0, gain_sel}, 1);
    chk("R12 rdata", {16'd0, list_rdata}, 0);

    // R4 R3: fill every page, then one extra write wraps to entry 0 (R5)
    for (int p = 0; p < 4; p++) begin
      ctl(3'd5, 2'(p));
      setwin('0, AW'(DEPTH - 1));
      for (int i = 0; i < DEPTH; i++) begin
        wr(pat(p, i));
        expm[p*DEPTH + i] = pat(p, i);
      end
      wr(pat(p, 99));
      expm[p*DEPTH] = pat(p, 99);
    end

    // R6 R1 R3: read all pages, one read past the final address wraps
    for (int p = 0; p < 4; p++) begin
      ctl(3'd4, 2'(p));
      setwin('0, AW'(DEPTH - 1));
      for (int k = 0; k <= DEPTH; k++) begin
        rd();
        chk("R6 addr", {24'd0, list_rdata[15:8]}, k % DEPTH);
        chk("R3 R1 entry", {24'd0, list_rdata[7:0]}, {24'd0, expm[p*DEPTH + (k % DEPTH)]});
      end
    end

    // R5: window 3..6 on page 2, five writes land on 3,4,5,6,3
    ctl(3'd5, 2'd2);
    setwin(AW'(3), AW'(6));
    for (int k = 0; k < 5; k++) begin
      wr(8'hA0 + 8'(k));
      expm[2*DEPTH + 3 + (k % 4)] = 8'hA0 + 8'(k);
    end
    ctl(3'd4, 2'd2);
    setwin(AW'(3), AW'(6));
    for (int k = 0; k < 6; k++) begin
      rd();
      chk("R5 wrap addr", {24'd0, list_rdata[15:8]}, 3 + (k % 4));
      chk("R5 wrap data", {24'd0, list_rdata[7:0]}, {24'd0, expm[2*DEPTH + 3 + (k % 4)]});
    end

    // R11: start write loads pointer
    @(negedge clk); bound_wdata = AW'(9); start_wr = 1;
    @(negedge clk); start_wr = 0;
    rd();
    chk("R11 ptr load", {24'd0, list_rdata[15:8]}, 9);

    // R8: writes in mode 0 and mode 7 change nothing
    ctl(3'd0, 2'd1);
    setwin(AW'(2), AW'(DEPTH - 1));
    wr(8'h55); wr(8'h66);
    ctl(3'd7, 2'd1);
    wr(8'h77);
    ctl(3'd4, 2'd1);
    for (int k = 0; k < 3; k++) begin
      rd();
      chk("R8 ptr kept", {24'd0, list_rdata[15:8]}, 2 + k);
      chk("R8 list kept", {24'd0, list_rdata[7:0]}, {24'd0, expm[DEPTH + 2 + k]});
    end

    // R7: preload from start of window 5..8 on page 3
    ctl(3'd6, 2'd3);
    setwin(AW'(5), AW'(8));
    wr(8'hFF);
    @(negedge clk);
    chk("R7 armed", {31'd0, armed}, 1);
    chk_out("R7 preload", 3*DEPTH + 5);

    // R9: conversions step 6,7,8 then wrap to 5
    ctl(3'd0, 2'd3);
    for (int k = 0; k < 6; k++) begin
      conv();
      chk_out("R9 step", 3*DEPTH + 5 + ((k + 1) % 4));
    end
    // after 6 steps the active entry is index 7

    // R10: not in mode 0 -> no step
    ctl(3'd5, 2'd3);
    conv();
    chk_out("R10 mode hold", 3*DEPTH + 7);
    ctl(3'd0, 2'd3);
    conv();
    chk_out("R9 resume", 3*DEPTH + 8);

    // R7: preload data was not stored
    ctl(3'd4, 2'd3);
    setwin(AW'(5), AW'(8));
    rd();
    chk("R7 data ignored", {24'd0, list_rdata[7:0]}, {24'd0, expm[3*DEPTH + 5]});

    // R12 then R10: reset disarms; conversions do nothing
    do_reset();
    chk("R12 disarm", {31'd0, armed}, 0);
    chk("R12 chan", {26'd0, chan_out}, 0);
    chk("R12 gain", {28'd0, gain_sel}, 1);
    conv();
    chk("R10 disarmed chan", {26'd0, chan_out}, 0);
    chk("R10 disarmed gain", {28'd0, gain_sel}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule